// File: doc/BRIEF.md
# Three-Phase Sign-Based Phase Detector with PI Tuning

This block produces the frequency-control word for an oscillator that drives a three-phase current-fed parallel resonant inverter. It needs no current sensor. Its only inputs are six flags: a positive-half flag and a negative-half flag for each of the three switch-node voltages, already digitized by comparators. For each phase it ANDs one flag of that switch with one flag of the switch before it in the cycle. This gives a leading window and a lagging window per phase. The six windows are combined into one small signed error per sample.

The error passes through a first-order exponential low-pass filter and then a PI stage. The result is added to a centre-frequency word, and the sum is clamped to a fixed range. The three phases' errors are summed before any filtering. The loop therefore drives the total to zero, and the switching frequency settles at the mean of the three tank frequencies rather than at the frequency of any single tank. The raw error ripples at six times the switching frequency.

Top module: `pd3_phase_tune`

## Requirements
- R1: While reset is high, and on the first edge after it, raw_err_o = 0, filt_err_o = 0 and freq_word_o = CENTER. Reset also clears the integrator.
- R2: Bit k of sw_pos_i and sw_neg_i belongs to switch k+1. The previous switch of phase 0 is switch index 2, and the previous switch of phase k is switch index k-1. Phase k has a lead term neg[k] & pos[prev], which weighs -1, and a lag term pos[k] & neg[prev], which weighs +1.
- R3: raw_err_o is a 3-bit two's-complement value. It equals the count of active lag terms minus the count of active lead terms, and it is registered one clock after the flags are sampled.
- R4: The filter state f (FRAC fractional bits) is updated every clock from the registered raw error a as f' = f + ((a*2^FRAC - f) >>> LPF_SHIFT), using an arithmetic (flooring) shift. It is shown on filt_err_o.
- R5: The integrator i is updated as i' = i + KI*f and saturates to the range [-2^(IW-1), 2^(IW-1)-1] instead of wrapping.
- R6: freq_word_o' = clamp(CENTER + ((KP*f + i) >>> OUT_SHIFT), MIN_WORD, MAX_WORD). Here f and i are the values held before the same clock edge.
- R7: Flag patterns in which leads and lags cancel produce a raw error of 0. A loop fed only such patterns after reset holds freq_word_o at CENTER.
- R8: freq_word_o never leaves [MIN_WORD, MAX_WORD]. Under a sustained one-sided error it reaches the matching limit and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sw_pos_i | input | 3 | Positive-half flags, bit k = switch k+1 |
| sw_neg_i | input | 3 | Negative-half flags, bit k = switch k+1 |
| raw_err_o | output | 3 | Signed raw phase error |
| filt_err_o | output | FRAC+4 | Signed filtered error, FRAC fractional bits |
| freq_word_o | output | CTRL_W | Clamped frequency-control word |

## Verification
A table of flag patterns targets each single lead window and each single lag window in turn. This separates the six product terms from one another and confirms the cyclic choice of neighbour. The table also holds cancelling and all-set patterns that must give zero, which separates a correct signed sum from a count of active terms. Long runs with one-sided error of each sign are compared cycle by cycle against a model built from R4 to R6. These runs tell apart the floor behaviour of the filter, integrator saturation versus wrap, and each output clamp. A cancelling-only run after reset shows that the word stays at the centre value.

// File: rtl/pd3_pkg.sv
package pd3_pkg;

   // Saturate/clamp an integer into [lo, hi]
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/pd3_sign_detect.sv
module pd3_sign_detect #(
   parameter int PHASES = 3,
   parameter int ERR_W  = $clog2(2 * PHASES + 1)
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [PHASES-1:0]       pos_i,
   input  logic [PHASES-1:0]       neg_i,
   output logic signed [ERR_W-1:0] err_o
);

   logic [PHASES-1:0] lead_w;
   logic [PHASES-1:0] lag_w;
   logic signed [ERR_W-1:0] err_d;

   // Window per phase against the cyclically previous switch
   for (genvar k = 0; k < PHASES; k++) begin : g_phase
      localparam int PREV = (k == 0) ? PHASES - 1 : k - 1;
      assign lead_w[k] = neg_i[k] & pos_i[PREV];
      assign lag_w[k]  = pos_i[k] & neg_i[PREV];
   end

   always_comb begin
      int diff;
      diff  = $countones(lag_w) - $countones(lead_w);
      err_d = ERR_W'(diff);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) err_o <= '0;
      else       err_o <= err_d;
   end

   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (pos_i == '0 && neg_i == '0) |=> (err_o == '0))
      else $error("idle flags gave nonzero error"); // R2

   AST_ALL_SET_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (&pos_i && &neg_i) |=> (err_o == '0))
      else $error("all flags set gave nonzero error"); // R7

endmodule

// File: rtl/pd3_lpf.sv
module pd3_lpf #(
   parameter int IN_W  = 3,
   parameter int FRAC  = 4,
   parameter int SHIFT = 3,
   parameter int OUT_W = IN_W + FRAC + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic signed [IN_W-1:0]  in_i,
   output logic signed [OUT_W-1:0] filt_o
);

   int tgt;
   int cur;
   int nxt;

   always_comb begin
      tgt = int'(in_i) * (2 ** FRAC);
      cur = int'(filt_o);
      nxt = cur + ((tgt - cur) >>> SHIFT);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) filt_o <= '0;
      else       filt_o <= OUT_W'(nxt);
   end

   AST_FILT_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
      (tgt > cur) |=> (filt_o >= $past(filt_o)))
      else $error("filter moved away from a higher target"); // R4

   AST_FILT_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
      (tgt < cur) |=> (filt_o < $past(filt_o)))
      else $error("filter failed to fall toward a lower target"); // R4

endmodule

// File: rtl/pd3_pi.sv
module pd3_pi
   import pd3_pkg::*;
#(
   parameter int IN_W      = 8,
   parameter int IW        = 16,
   parameter int KP        = 20,
   parameter int KI        = 1,
   parameter int OUT_SHIFT = 4,
   parameter int CTRL_W    = 16,
   parameter int CENTER    = 6500,
   parameter int MIN_WORD  = 5000,
   parameter int MAX_WORD  = 8000
) (
   input  logic                   clk_i,
   input  logic                   rst_i,
   input  logic signed [IN_W-1:0] err_i,
   output logic [CTRL_W-1:0]      ctrl_o
);

   localparam int I_MAX = (2 ** (IW - 1)) - 1;
   localparam int I_MIN = -(2 ** (IW - 1));

   logic signed [IW-1:0] integ;

   if (KI == 0) begin : g_p_only
      assign integ = '0;
   end else begin : g_pi
      always_ff @(posedge clk_i) begin
         if (rst_i) integ <= '0;
         else integ <= IW'(clamp_int(int'(integ) + KI * int'(err_i), I_MIN, I_MAX));
      end
   end

   int word_d;
   always_comb begin
      word_d = clamp_int(CENTER + ((KP * int'(err_i) + int'(integ)) >>> OUT_SHIFT),
                         MIN_WORD, MAX_WORD);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) ctrl_o <= CTRL_W'(CENTER);
      else       ctrl_o <= CTRL_W'(word_d);
   end

   AST_INTEG_NO_WRAP_UP: assert property (@(posedge clk_i) disable iff (rst_i)
      (integ >= 0 && err_i >= 0) |=> (integ >= $past(integ)))
      else $error("integrator wrapped downward"); // R5

   AST_INTEG_NO_WRAP_DN: assert property (@(posedge clk_i) disable iff (rst_i)
      (integ <= 0 && err_i <= 0) |=> (integ <= $past(integ)))
      else $error("integrator wrapped upward"); // R5

   AST_CTRL_BOUNDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (int'(ctrl_o) >= MIN_WORD && int'(ctrl_o) <= MAX_WORD))
      else $error("control word out of range"); // R8

endmodule

// File: rtl/pd3_phase_tune.sv
module pd3_phase_tune #(
   parameter int FRAC      = 4,
   parameter int LPF_SHIFT = 3,
   parameter int IW        = 16,
   parameter int KP        = 20,
   parameter int KI        = 1,
   parameter int OUT_SHIFT = 4,
   parameter int CTRL_W    = 16,
   parameter int CENTER    = 6500,
   parameter int MIN_WORD  = 5000,
   parameter int MAX_WORD  = 8000
) (
   input  logic                   clk_i,
   input  logic                   rst_i,
   input  logic [2:0]             sw_pos_i,
   input  logic [2:0]             sw_neg_i,
   output logic signed [2:0]      raw_err_o,
   output logic signed [FRAC+3:0] filt_err_o,
   output logic [CTRL_W-1:0]      freq_word_o
);

   localparam int PHASES = 3;
   localparam int ERR_W  = 3;
   localparam int FW     = ERR_W + FRAC + 1;

   if (LPF_SHIFT < 1 || LPF_SHIFT > 16) begin : g_bad_shift
      $error("LPF_SHIFT must be 1..16");
   end
   if (IW < 4 || IW > 30) begin : g_bad_iw
      $error("IW must be 4..30");
   end
   if (MIN_WORD > CENTER || CENTER > MAX_WORD) begin : g_bad_range
      $error("CENTER must lie within MIN_WORD..MAX_WORD");
   end
   if (MAX_WORD >= 2 ** CTRL_W || MIN_WORD < 0) begin : g_bad_ctrl
      $error("word limits must fit CTRL_W");
   end

   pd3_sign_detect #(.PHASES(PHASES), .ERR_W(ERR_W)) det_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .pos_i (sw_pos_i),
      .neg_i (sw_neg_i),
      .err_o (raw_err_o)
   );

   pd3_lpf #(.IN_W(ERR_W), .FRAC(FRAC), .SHIFT(LPF_SHIFT), .OUT_W(FW)) lpf_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .in_i   (raw_err_o),
      .filt_o (filt_err_o)
   );

   pd3_pi #(
      .IN_W(FW), .IW(IW), .KP(KP), .KI(KI), .OUT_SHIFT(OUT_SHIFT),
      .CTRL_W(CTRL_W), .CENTER(CENTER), .MIN_WORD(MIN_WORD), .MAX_WORD(MAX_WORD)
   ) pi_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .err_i  (filt_err_o),
      .ctrl_o (freq_word_o)
   );

   AST_RESET_CENTER: assert property (@(posedge clk_i)
      $fell(rst_i) |-> (int'(freq_word_o) == CENTER && filt_err_o == '0))
      else $error("outputs not at reset state"); // R1

endmodule

// File: tb/pd3_phase_tune_tb_top.sv
module pd3_phase_tune_tb_top;
   import pd3_pkg::*;

   localparam int FRAC = 4, LPF_SHIFT = 3, IW = 16, KP = 20, KI = 1, OUT_SHIFT = 4;
   localparam int CTRL_W = 16, CENTER = 6500, MIN_WORD = 5000, MAX_WORD = 8000;

   // {pos[2:0], neg[2:0], expected raw error (3-bit two's complement)}
   localparam logic [8:0] VEC [0:11] = '{
      {3'b000, 3'b000, 3'b000},
      {3'b100, 3'b001, 3'b111},
      {3'b001, 3'b100, 3'b001},
      {3'b111, 3'b111, 3'b000},
      {3'b001, 3'b010, 3'b111},
      {3'b010, 3'b001, 3'b001},
      {3'b010, 3'b100, 3'b111},
      {3'b100, 3'b010, 3'b001},
      {3'b001, 3'b001, 3'b000},
      {3'b110, 3'b001, 3'b000},
      {3'b110, 3'b011, 3'b001},
      {3'b101, 3'b011, 3'b111}
   };

   logic clk = 1'b0;
   logic rst;
   logic [2:0] pos, neg;
   logic signed [2:0] raw;
   logic signed [FRAC+3:0] filt;
   logic [CTRL_W-1:0] word;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   int m_raw, m_f, m_i, m_c;

   always #5 clk = ~clk;

   pd3_phase_tune #(
      .FRAC(FRAC), .LPF_SHIFT(LPF_SHIFT), .IW(IW), .KP(KP), .KI(KI), .OUT_SHIFT(OUT_SHIFT),
      .CTRL_W(CTRL_W), .CENTER(CENTER), .MIN_WORD(MIN_WORD), .MAX_WORD(MAX_WORD)
   ) dut_i (
      .clk_i(clk), .rst_i(rst), .sw_pos_i(pos), .sw_neg_i(neg),
      .raw_err_o(raw), .filt_err_o(filt), .freq_word_o(word)
   );

   // Raw error from the R2 window definition
   function automatic int win_err(input logic [2:0] p, input logic [2:0] n);
      int s = 0;
      for (int k = 0; k < 3; k++) begin
         int pv = (k == 0) ? 2 : k - 1;
         if (n[k] && p[pv]) s -= 1;
         if (p[k] && n[pv]) s += 1;
      end
      return s;
   endfunction

   // Reference model of R4..R6, stepped at every rising edge
   always @(posedge clk) begin
      int n_raw, n_f, n_i, n_c;
      if (rst) begin
         m_raw = 0; m_f = 0; m_i = 0; m_c = CENTER;
      end else begin
         n_raw = win_err(pos, neg);
         n_f   = m_f + ((m_raw * (2 ** FRAC) - m_f) >>> LPF_SHIFT);
         n_i   = clamp_int(m_i + KI * m_f, -(2 ** (IW - 1)), (2 ** (IW - 1)) - 1);
         n_c   = clamp_int(CENTER + ((KP * m_f + m_i) >>> OUT_SHIFT), MIN_WORD, MAX_WORD);
         m_raw = n_raw; m_f = n_f; m_i = n_i; m_c = n_c;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pos = '0; neg = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic run_const(input logic [2:0] p, input logic [2:0] n, input int cycles,
                            output bit hit_max, output bit hit_min);
      hit_max = 1'b0; hit_min = 1'b0;
      pos = p; neg = n;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         check("R4 filt", int'(filt), m_f);
         check("R6 word", int'(word), m_c);
         if (int'(word) < MIN_WORD || int'(word) > MAX_WORD)
            check("R8 bounds", int'(word), MIN_WORD);
         if (int'(word) == MAX_WORD) hit_max = 1'b1;
         if (int'(word) == MIN_WORD) hit_min = 1'b1;
      end
   endtask

   initial begin
      bit hmax, hmin;
      rst = 1'b1; pos = '0; neg = '0;
      repeat (3) @(negedge clk);
      check("R1 raw", int'(raw), 0);
      check("R1 filt", int'(filt), 0);
      check("R1 word", int'(word), CENTER);
      rst = 1'b0;
      @(negedge clk);
      check("R1 word after release", int'(word), CENTER);

      // R2/R3: table walk, one pattern per cycle
      for (int v = 0; v < 12; v++) begin
         pos = VEC[v][8:6]; neg = VEC[v][5:3];
         @(negedge clk);
         check($sformatf("R2 R3 raw vec%0d", v), int'(raw), int'($signed(VEC[v][2:0])));
         check("R4 filt", int'(filt), m_f);
         check("R6 word", int'(word), m_c);
      end

      // R7: cancelling pattern only, word must hold the centre
      do_reset();
      pos = 3'b110; neg = 3'b001;
      repeat (40) @(negedge clk);
      check("R7 raw cancel", int'(raw), 0);
      check("R7 filt cancel", int'(filt), 0);
      check("R7 word centre", int'(word), CENTER);

      // R5/R6/R8: sustained lag error, then sustained lead error
      do_reset();
      run_const(3'b001, 3'b100, 5000, hmax, hmin);
      check("R8 reached MAX_WORD", int'(hmax), 1);
      run_const(3'b100, 3'b001, 9000, hmax, hmin);
      check("R8 reached MIN_WORD", int'(hmin), 1);
      check("R5 saturated low word", int'(word), MIN_WORD);

      // R1: reset mid-run returns outputs to the initial state
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 word on reset", int'(word), CENTER);
      check("R1 filt on reset", int'(filt), 0);
      rst = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule